// File: doc/BRIEF.md
# Chainable Three-Wire Stereo Gain Receiver

This block is a serial slave that takes a 16-bit stereo gain word from a host over three wires (active-low select, serial clock, serial data) and hands two 8-bit gain codes to downstream gain logic. All three serial pins are oversampled by a much faster system clock. Each pin passes through a two-flop synchronizer, and the serial clock and select edges are found from the synchronized levels.

While select is low, each rising serial-clock edge shifts one data bit into a 16-bit register. When select rises, the register is copied into the right and left gain holding registers, and a one-cycle strobe is raised. On each falling serial-clock edge, the bit at the far end of the register is driven on the data output. That bit entered 16 rising edges earlier, so several identical blocks wired data-out to data-in behave as one long shift register. The data output comes with an enable for the pad's three-state driver. The enable is low whenever select is high.

Top module: `serial_gain_port`

## Requirements
- R1: After a synchronous active-low reset, both gain codes are 0, the strobe is 0, the data output is 0 and the output enable is 0.
- R2: A frame of 16 bits is sent most significant bit first. The first 8 bits form the right gain code and the last 8 bits form the left gain code, both straight binary. The gain outputs change only in the cycle in which the strobe is high.
- R3: Each rising edge of select produces exactly one strobe, one system clock wide. The new gain codes appear in that same cycle, on the third system clock edge after select rises at the pin.
- R4: Data is sampled on the rising serial-clock edge, and only while select is low. Serial-clock edges while select is high leave the shift register unchanged. A later frame with no clock edges therefore relatches the previous word.
- R5: On each falling serial-clock edge while select is low, the data output takes the bit that entered 16 rising edges earlier (0 before 16 bits have arrived since reset). Two chained blocks that receive a 32-bit frame therefore end with the first 16 bits in the second block and the last 16 bits in the first.
- R6: The output enable is the inverse of select, delayed by two system clocks.
- R7: If a frame has a bit count that is not a multiple of 16, the last 16 bits received are latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, to the next block in the chain |
| sdo_oe | output | 1 | High when the pad should drive sdo, low for high impedance |
| gain_right | output | 8 | Right channel gain code |
| gain_left | output | 8 | Left channel gain code |
| gain_stb | output | 1 | One-cycle pulse when new gain codes are latched |

## Verification
The bench covers these corner cases:

- **Byte order and bit order.** Asymmetric words such as 0xA53C expose a design that swaps the channels or reverses the bits.
- **Clocks while select is high.** The bench toggles the serial clock with select high, then sends a frame with no clocks. A design that shifts while deselected latches ones instead of the old word.
- **Over-long frames.** Frames of 20 and 32 bits show whether the design keeps the newest 16 bits or stops after the first 16.
- **Daisy chain.** A second block on the data output checks that the pass-through delay is exactly 16 bits. An off-by-one design leaves the second block with a shifted word.
- **Cycle-level behaviour.** A per-clock reference model of the synchronizer delay catches a strobe that is late, early or two cycles wide.

// File: rtl/sgp_pkg.sv
// Shared defaults for the serial gain port.
// Assumes: two channels, each with one gain code of equal width.
package sgp_pkg;
    localparam int CODE_W_DEF = 8;
    localparam int SYNC_STAGES_DEF = 2;
    localparam int CHAN_COUNT = 2;

    // Rise/fall event pair derived from a synchronized level.
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    // Edge events from the current synchronized level and last cycle's level.
    function automatic edge_t find_edges(input logic now_lvl, input logic last_lvl);
        edge_t e;
        e.rise = now_lvl & ~last_lvl;
        e.fall = ~now_lvl & last_lvl;
        return e;
    endfunction
endpackage

// File: rtl/sgp_sync.sv
// Multi-flop synchronizer for one asynchronous pin.
// Assumes: the pin is a slow level, sampled much faster than it changes.
module sgp_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    // Shift the pin level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= {STAGES{RST_VAL}};
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/sgp_shift.sv
// Serial shift register with chain pass-through output.
// Shifts on a synchronized serial-clock rise while select is low.
// Launches the oldest bit on a serial-clock fall while select is low.
// Assumes: inputs are already synchronized to clk.
module sgp_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              sdi_s,
    output logic [WORD_W-1:0] word,
    output logic              sdo
);
    import sgp_pkg::*;

    logic  sclk_q;
    edge_t sclk_ev;

    // Remember last cycle's serial-clock level for edge finding.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    assign sclk_ev = find_edges(sclk_s, sclk_q);

    // Shift one bit in on each selected rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                     word <= '0;
        else if (sclk_ev.rise && !cs_n_s) word <= {word[WORD_W-2:0], sdi_s};
    end

    // Launch the far-end bit on each selected falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                     sdo <= 1'b0;
        else if (sclk_ev.fall && !cs_n_s) sdo <= word[WORD_W-1];
    end

    // R4
    shift_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> $stable(word))
        else $error("shift register moved while deselected");

    // R5
    sdo_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_ev.fall || cs_n_s) |=> $stable(sdo))
        else $error("sdo changed without a selected falling edge");
endmodule

// File: rtl/sgp_hold.sv
// Gain holding registers with update strobe.
// Copies the shift word on a synchronized select rise.
// Assumes: the right code sits in the upper half of the word.
module sgp_hold #(
    parameter int CODE_W = 8,
    localparam int WORD_W = 2 * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic [WORD_W-1:0] word,
    output logic [CODE_W-1:0] gain_right,
    output logic [CODE_W-1:0] gain_left,
    output logic              gain_stb
);
    import sgp_pkg::*;

    logic  cs_q;
    edge_t cs_ev;

    // Remember last cycle's select level for edge finding.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b1;
        else        cs_q <= cs_n_s;
    end

    assign cs_ev = find_edges(cs_n_s, cs_q);

    // Latch both codes and pulse the strobe when select rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_right <= '0;
            gain_left  <= '0;
            gain_stb   <= 1'b0;
        end else begin
            gain_stb <= cs_ev.rise;
            if (cs_ev.rise) begin
                gain_right <= word[WORD_W-1 -: CODE_W];
                gain_left  <= word[CODE_W-1:0];
            end
        end
    end

    // R3
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gain_stb |=> !gain_stb)
        else $error("strobe wider than one cycle");

    // R2
    gain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gain_stb |-> ($stable(gain_right) && $stable(gain_left)))
        else $error("gain changed without strobe");
endmodule

// File: rtl/serial_gain_port.sv
// Chainable three-wire stereo gain receiver.
// Synchronizes the pins, shifts serial data, and latches the gain codes.
// Assumes: clk is at least eight times faster than sclk.
module serial_gain_port #(
    parameter int CODE_W      = sgp_pkg::CODE_W_DEF,
    parameter int SYNC_STAGES = sgp_pkg::SYNC_STAGES_DEF,
    localparam int WORD_W     = sgp_pkg::CHAN_COUNT * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [CODE_W-1:0] gain_right,
    output logic [CODE_W-1:0] gain_left,
    output logic              gain_stb
);
    localparam int NPINS = 3;
    localparam logic [NPINS-1:0] PIN_RST = 3'b001;  // bit0 select idles high

    logic [NPINS-1:0]  pins_raw;
    logic [NPINS-1:0]  pins_s;
    logic [WORD_W-1:0] word;

    assign pins_raw = {sdi, sclk, cs_n};

    for (genvar gi = 0; gi < NPINS; gi++) begin : g_sync
        sgp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_RST[gi])) u_sync (
            .clk(clk), .rst_n(rst_n), .d(pins_raw[gi]), .q(pins_s[gi])
        );
    end

    sgp_shift #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .sclk_s(pins_s[1]), .cs_n_s(pins_s[0]), .sdi_s(pins_s[2]),
        .word(word), .sdo(sdo)
    );

    sgp_hold #(.CODE_W(CODE_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .cs_n_s(pins_s[0]), .word(word),
        .gain_right(gain_right), .gain_left(gain_left), .gain_stb(gain_stb)
    );

    assign sdo_oe = ~pins_s[0];

    // R6
    oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 1) && $past(rst_n, 2)) |-> (sdo_oe == !$past(cs_n, 2)))
        else $error("output enable does not track select");
endmodule

// File: tb/serial_gain_port_bench.sv
module serial_gain_port_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic sdo, sdo_oe, gain_stb;
    logic [7:0] gain_right, gain_left;
    logic sdo2, sdo_oe2, gain_stb2;
    logic [7:0] gain_right2, gain_left2;

    int checks = 0;
    int failures = 0;
    int stb_count = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    serial_gain_port u_serial_gain_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .gain_right(gain_right),
        .gain_left(gain_left), .gain_stb(gain_stb)
    );

    serial_gain_port u_serial_gain_port_next (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdo),
        .sdo(sdo2), .sdo_oe(sdo_oe2), .gain_right(gain_right2),
        .gain_left(gain_left2), .gain_stb(gain_stb2)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference: pin history with a two-clock sync delay.
    logic h_cs[4], h_sc[4], h_sd[4];
    logic q[$];
    logic m_sdo, m_oe, m_stb;
    logic [15:0] m_gain;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin h_cs[i] = 1; h_sc[i] = 0; h_sd[i] = 0; end
            q = {};
            for (int i = 0; i < 16; i++) q.push_back(1'b0);
            m_sdo = 0; m_oe = 0; m_stb = 0; m_gain = 0;
            model_on = 1'b1;
        end else begin
            for (int i = 3; i > 0; i--) begin
                h_cs[i] = h_cs[i-1]; h_sc[i] = h_sc[i-1]; h_sd[i] = h_sd[i-1];
            end
            h_cs[0] = cs_n; h_sc[0] = sclk; h_sd[0] = sdi;
            m_stb = h_cs[2] && !h_cs[3];
            if (m_stb)
                for (int i = 0; i < 16; i++) m_gain = {m_gain[14:0], q[i]};
            if (!h_cs[2] && !h_sc[2] && h_sc[3]) m_sdo = q[0];
            if (!h_cs[2] && h_sc[2] && !h_sc[3]) begin
                q.push_back(h_sd[2]);
                void'(q.pop_front());
            end
            m_oe = !h_cs[1];
        end
    end

    // Compare against the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (model_on && !done) begin
            chk(sdo == m_sdo, "R5 sdo per-cycle", {31'd0, sdo}, {31'd0, m_sdo});
            chk(sdo_oe == m_oe, "R6 oe per-cycle", {31'd0, sdo_oe}, {31'd0, m_oe});
            chk(gain_stb == m_stb, "R3 strobe per-cycle", {31'd0, gain_stb}, {31'd0, m_stb});
            chk({gain_right, gain_left} == m_gain, "R2 gains per-cycle",
                {16'd0, gain_right, gain_left}, {16'd0, m_gain});
            if (gain_stb) stb_count++;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send n bits of v, most significant first, then raise select.
    task automatic send(input logic [63:0] v, input int n);
        cs_n = 1'b0;
        wait_clk(8);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = v[i];
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(8);
            sclk = 1'b0;
            wait_clk(4);
        end
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(10);
    endtask

    task automatic frame_gain(input logic [63:0] v, input int n,
                              input logic [7:0] er, input logic [7:0] el,
                              input string tag);
        stb_count = 0;
        send(v, n);
        chk(gain_right == er, tag, {24'd0, gain_right}, {24'd0, er});
        chk(gain_left == el, tag, {24'd0, gain_left}, {24'd0, el});
        chk(stb_count == 1, "R3 one strobe per frame", stb_count, 1);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        // R1 reset state
        chk(gain_right == 0 && gain_left == 0, "R1 gains at reset",
            {gain_right, gain_left}, 0);
        chk(gain_stb == 0 && sdo == 0 && sdo_oe == 0, "R1 strobe/sdo/oe at reset",
            {gain_stb, sdo, sdo_oe}, 0);
        rst_n = 1'b1;
        wait_clk(4);

        // R2 byte order and bit order
        frame_gain(64'hA53C, 16, 8'hA5, 8'h3C, "R2 word A53C");
        frame_gain(64'h00FF, 16, 8'h00, 8'hFF, "R2 word 00FF");

        // R6 enable high mid-frame
        cs_n = 1'b0;
        wait_clk(6);
        chk(sdo_oe == 1, "R6 oe during select", {31'd0, sdo_oe}, 1);
        cs_n = 1'b1;
        wait_clk(6);
        chk(sdo_oe == 0, "R6 oe after deselect", {31'd0, sdo_oe}, 0);
        frame_gain(64'hA53C, 16, 8'hA5, 8'h3C, "R2 word A53C again");

        // R4 clocks while deselected must not shift
        sdi = 1'b1;
        for (int i = 0; i < 5; i++) begin
            sclk = 1'b1; wait_clk(8); sclk = 1'b0; wait_clk(8);
        end
        frame_gain(64'h0, 0, 8'hA5, 8'h3C, "R4 empty frame relatches");

        // R7 over-long frame keeps the newest 16 bits
        frame_gain(64'h1_2345, 20, 8'h23, 8'h45, "R7 20-bit frame");

        // R5 chain of two
        frame_gain(64'h1122_3344, 32, 8'h33, 8'h44, "R7 32-bit frame first block");
        chk(gain_right2 == 8'h11, "R5 chain second right", {24'd0, gain_right2}, 32'h11);
        chk(gain_left2 == 8'h22, "R5 chain second left", {24'd0, gain_left2}, 32'h22);

        frame_gain(64'hFF00, 16, 8'hFF, 8'h00, "R2 word FF00");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule